// File: doc/BRIEF.md
# SPI Serial Clock Divider with Burst Edge Budget

This block derives the serial clock of an SPI master from a faster reference clock. The ratio is set by two fields that multiply. A linear field `lin_div` divides by 1 to 16. An exponent field `pow_div` then divides by a power of two, from 2^0 to 2^15. The result is a one-cycle strobe for every half-period of the serial clock, together with the serial clock level itself. The level rests at a programmable polarity whenever no burst runs.

A burst starts when `enable` rises. It produces exactly twice `burst_bits` clock edges, then holds the clock at its idle level until `enable` is lowered. Each edge is also labelled as a sample edge or a shift edge, following the clock-phase input. The surrounding shifter can then capture and launch data without decoding edges itself. Both divider stages restart at a burst start and whenever either divider field changes value.

Top module: `spi_sclk_divider`

## Requirements
- R1: With `enable` first sampled high at clock edge 0, `edge_stb` is high for exactly one cycle after edges D-1, 2D-1, 3D-1 and so on, where D = (lin_div+1)·2^pow_div reference cycles. It is low in every other cycle.
- R2: With `lin_div` = 0 and `pow_div` = 0, D is 1, so `edge_stb` is high in every cycle of the burst.
- R3: The two stages reach their extremes independently. `pow_div` = 15 with `lin_div` = 0 gives D = 32768, and `lin_div` = 15 gives a factor of 16 on top of any exponent.
- R4: While `enable` is high, `sclk` inverts in exactly those cycles in which `edge_stb` is high.
- R5: Out of reset, and one cycle after any edge at which `enable` is low, `sclk` equals `cpol` and all strobes are low. Lowering `enable` clears both divider stages and the edge count.
- R6: A burst produces exactly 2·`burst_bits` strobes. `burst_bits` = 0 gives none. After the last strobe, `sclk` rests at `cpol` and no further strobe occurs while `enable` stays high.
- R7: Number the strobes of a burst from 1. Odd strobes are leading edges and even strobes are trailing edges. With `cpha` = 0, `sample_stb` accompanies odd strobes and `shift_stb` accompanies even ones. With `cpha` = 1 the roles swap. Exactly one of the two accompanies each `edge_stb`, and neither is high without it.
- R8: Suppose `lin_div` or `pow_div` holds a different value at edge j than at edge j-1 during a burst. Both stages then restart, and the next strobe is high after edge j+D, where D is computed from the new values. `sclk` is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Burst active; rising starts a burst, low forces idle |
| lin_div | input | PRE_W (4) | Linear stage setting, divide by value+1 |
| pow_div | input | POST_W (4) | Exponent stage setting, divide by 2^value |
| burst_bits | input | BITS_W (8) | Bits per burst; edges = 2·value |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0: sample on leading edges, 1: sample on trailing edges |
| edge_stb | output | 1 | One-cycle strobe per serial clock edge |
| sample_stb | output | 1 | Strobe on edges where data is captured |
| shift_stb | output | 1 | Strobe on edges where data is launched |
| sclk | output | 1 | Serial clock level |

## Verification
The properties assume that `cpol` and `burst_bits` stay constant while `enable` is high. They also assume that `enable` is low for at least one edge between bursts, so that every burst begins from a clock already resting at the new polarity. The stimulus therefore applies each new configuration with `enable` low, lets one edge pass, and only then raises `enable`. Only the divider fields change during a burst, and only in the dedicated restart test. The sweep covers every linear setting against the low exponents, plus both stage extremes, and compares every cycle against arithmetic predictions.

// File: rtl/spi_clkdiv_pkg.sv
// Shared types for the serial clock divider.
// Assumes nothing beyond a single reference clock domain.
package spi_clkdiv_pkg;

    // Strobes emitted together for one serial clock edge
    typedef struct packed {
        logic edge_hit;
        logic sample;
        logic shift;
    } sclk_strobe_t;

endpackage

// File: rtl/spi_lin_stage.sv
// Linear divider stage: counts 0..lin and raises tick on the wrap cycle.
// Assumes clear is held for at least one edge to restart the count.
module spi_lin_stage #(
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [PRE_W-1:0] lin,
    output logic             tick
);

    logic [PRE_W-1:0] cnt;

    // Combinational wrap detect; suppressed while restarting
    assign tick = !clear && (cnt == lin);

    // Advance the count, wrapping after it reaches the setting
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (cnt == lin) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + PRE_W'(1);
        end
    end

endmodule

// File: rtl/spi_pow_stage.sv
// Power-of-two divider stage: counts linear ticks and passes every
// 2^pow-th one. With pow = 0 every tick passes straight through.
// Assumes step is already gated by clear upstream.
module spi_pow_stage #(
    parameter int POST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [POST_W-1:0] pow,
    output logic              div_edge
);

    localparam int CNT_W = (1 << POST_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mask;

    // Build a mask of the low pow bits
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            mask[i] = (i < int'(pow));
        end
    end

    // An edge occurs when the low pow bits are about to carry
    assign div_edge = step && ((cnt & mask) == mask);

    // Count linear ticks; restart on clear
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/spi_sclk_shaper.sv
// Turns divider edges into the serial clock level and the labelled
// strobes, and stops after 2*burst_bits edges.
// Assumes cpol and burst_bits are stable while enable is high.
module spi_sclk_shaper
    import spi_clkdiv_pkg::*;
#(
    parameter int BITS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [BITS_W-1:0] burst_bits,
    input  logic              div_edge,
    output logic              sclk,
    output sclk_strobe_t      stb
);

    localparam int EC_W = BITS_W + 1;

    logic [EC_W-1:0] edge_cnt;
    logic [EC_W-1:0] budget;
    logic            fire;

    assign budget = {burst_bits, 1'b0};
    // A divider edge counts only while the burst budget is not used up
    assign fire   = enable && (edge_cnt != budget) && div_edge;

    // Register level, edge count and labelled strobes
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            edge_cnt <= '0;
            sclk     <= cpol;
            stb      <= '0;
        end else begin
            stb.edge_hit <= fire;
            stb.sample   <= fire && (edge_cnt[0] == cpha);
            stb.shift    <= fire && (edge_cnt[0] != cpha);
            if (fire) begin
                edge_cnt <= edge_cnt + EC_W'(1);
                sclk     <= ~sclk;
            end
        end
    end

endmodule

// File: rtl/spi_sclk_divider.sv
// Two-stage serial clock divider for an SPI master. Half-period
// strobe rate is clk / (lin_div+1) / 2^pow_div. Stages restart when
// enable is low or either divider field changes value.
// Assumes synchronous inputs in the clk domain.
module spi_sclk_divider
    import spi_clkdiv_pkg::*;
#(
    parameter int PRE_W  = 4,
    parameter int POST_W = 4,
    parameter int BITS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [PRE_W-1:0]  lin_div,
    input  logic [POST_W-1:0] pow_div,
    input  logic [BITS_W-1:0] burst_bits,
    input  logic              cpol,
    input  logic              cpha,
    output logic              edge_stb,
    output logic              sample_stb,
    output logic              shift_stb,
    output logic              sclk
);

    logic [PRE_W-1:0]  lin_q;
    logic [POST_W-1:0] pow_q;
    logic              fields_moved;
    logic              restart;
    logic              lin_tick;
    logic              div_edge;
    sclk_strobe_t      stb;

    assign fields_moved = (lin_div != lin_q) || (pow_div != pow_q);
    assign restart      = !enable || fields_moved;

    // Shadow the divider fields to detect a change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_q <= '0;
            pow_q <= '0;
        end else begin
            lin_q <= lin_div;
            pow_q <= pow_div;
        end
    end

    spi_lin_stage #(.PRE_W(PRE_W)) u_lin (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart),
        .lin   (lin_div),
        .tick  (lin_tick)
    );

    spi_pow_stage #(.POST_W(POST_W)) u_pow (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (restart),
        .step     (lin_tick),
        .pow      (pow_div),
        .div_edge (div_edge)
    );

    spi_sclk_shaper #(.BITS_W(BITS_W)) u_shape (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .cpol       (cpol),
        .cpha       (cpha),
        .burst_bits (burst_bits),
        .div_edge   (div_edge),
        .sclk       (sclk),
        .stb        (stb)
    );

    assign edge_stb   = stb.edge_hit;
    assign sample_stb = stb.sample;
    assign shift_stb  = stb.shift;

endmodule

// File: rtl/spi_sclk_divider_chk.sv
// Property checker for spi_sclk_divider, attached by bind.
// Assumes cpol and burst_bits are stable while enable is high.
module spi_sclk_divider_chk #(
    parameter int BITS_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              cpol,
    input logic [BITS_W-1:0] burst_bits,
    input logic              edge_stb,
    input logic              sample_stb,
    input logic              shift_stb,
    input logic              sclk
);

    localparam int SW = BITS_W + 2;

    logic [SW-1:0] seen;
    logic [SW-1:0] total;
    logic [SW-1:0] limit;

    assign total = seen + SW'(edge_stb);
    assign limit = SW'({burst_bits, 1'b0});

    // Count strobes observed in the current burst
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            seen <= '0;
        end else if (edge_stb) begin
            seen <= seen + SW'(1);
        end
    end

    p_idle_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (sclk == $past(cpol)));

    p_toggle_on_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> (edge_stb == (sclk != $past(sclk))));

    p_phase_split_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sample_stb, shift_stb}) == int'(edge_stb));

    p_edge_budget_r6: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> (total <= limit));

    p_rest_after_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (total == limit)) |-> (sclk == cpol));

endmodule

bind spi_sclk_divider spi_sclk_divider_chk #(.BITS_W(BITS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .cpol       (cpol),
    .burst_bits (burst_bits),
    .edge_stb   (edge_stb),
    .sample_stb (sample_stb),
    .shift_stb  (shift_stb),
    .sclk       (sclk)
);

// File: tb/spi_sclk_divider_test.sv
// Sweeping bench for spi_sclk_divider; predictions are arithmetic.
module spi_sclk_divider_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [3:0] lin_div = '0;
    logic [3:0] pow_div = '0;
    logic [7:0] burst_bits = '0;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic       edge_stb, sample_stb, shift_stb, sclk;

    int vectors = 0;
    int miscompares = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_sclk_divider uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .lin_div    (lin_div),
        .pow_div    (pow_div),
        .burst_bits (burst_bits),
        .cpol       (cpol),
        .cpha       (cpha),
        .edge_stb   (edge_stb),
        .sample_stb (sample_stb),
        .shift_stb  (shift_stb),
        .sclk       (sclk)
    );

    task automatic check_bit(input string req, input string what,
                             input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t",
                     req, what, act, exp, $time);
        end
    endtask

    // One burst; every cycle compared against D = (lin+1)*2^pw
    task automatic run_burst(input int lin, input int pw, input int bits,
                             input logic pol, input logic pha);
        int d;
        int total;
        string tag;
        @(negedge clk);
        enable     = 1'b0;
        lin_div    = 4'(lin);
        pow_div    = 4'(pw);
        burst_bits = 8'(bits);
        cpol       = pol;
        cpha       = pha;
        @(negedge clk);
        check_bit("R5", "idle sclk", sclk, pol);
        enable = 1'b1;
        d     = (lin + 1) << pw;
        total = 2 * bits * d + 3;
        if (lin == 0 && pw == 0)      tag = "R2";
        else if (lin == 15 || pw > 3) tag = "R3";
        else                          tag = "R1";
        for (int t = 0; t < total; t++) begin
            int k;
            int n;
            logic hit;
            logic lead;
            @(negedge clk);
            k    = (t + 1) / d;
            hit  = ((t + 1) % d == 0) && (k >= 1) && (k <= 2 * bits);
            n    = (k > 2 * bits) ? 2 * bits : k;
            lead = k[0];
            check_bit(k > 2 * bits ? "R6" : tag, "edge_stb", edge_stb, hit);
            check_bit(k >= 2 * bits ? "R6" : "R4", "sclk", sclk, pol ^ n[0]);
            check_bit("R7", "sample_stb", sample_stb, hit && (lead != pha));
            check_bit("R7", "shift_stb", shift_stb, hit && (lead == pha));
        end
        enable = 1'b0;
        @(negedge clk);
        check_bit("R5", "sclk after drop", sclk, pol);
        check_bit("R5", "edge after drop", edge_stb, 1'b0);
    endtask

    // Divider fields change mid-burst; restart timing checked
    task automatic run_restart();
        @(negedge clk);
        enable     = 1'b0;
        lin_div    = 4'd3;
        pow_div    = 4'd1;
        burst_bits = 8'd4;
        cpol       = 1'b0;
        cpha       = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        for (int t = 0; t < 5; t++) begin
            @(negedge clk);
            check_bit("R8", "edge before change", edge_stb, 1'b0);
        end
        lin_div = 4'd3;
        pow_div = 4'd0;
        for (int t = 5; t <= 9; t++) begin
            @(negedge clk);
            check_bit("R8", "edge after change", edge_stb, t == 9);
            check_bit("R8", "sclk after change", sclk, t == 9);
        end
        enable = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        fork
            begin
                cpol = 1'b1;
                repeat (3) @(posedge clk);
                @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                check_bit("R5", "reset sclk", sclk, 1'b1);
                check_bit("R5", "reset edge", edge_stb, 1'b0);
                check_bit("R5", "reset sample", sample_stb, 1'b0);
                for (int pw = 0; pw < 4; pw++) begin
                    for (int lin = 0; lin < 16; lin++) begin
                        run_burst(lin, pw, 1 + (lin % 3), lin[0], lin[1]);
                    end
                end
                run_burst(0, 0, 0, 1'b1, 1'b0);
                run_burst(2, 1, 0, 1'b0, 1'b1);
                run_restart();
                run_burst(0, 15, 1, 1'b0, 1'b1);
                run_burst(15, 10, 1, 1'b1, 1'b0);
            end
            begin
                repeat (WATCHDOG) @(posedge clk);
                miscompares++;
                $display("FAIL watchdog expired: actual hung expected finish");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule